// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the command front end of a byte-wide parallel NOR flash. It sees each bus write as a one-cycle strobe that carries an address and a data byte. It tracks the unlock handshake that must come before every multi-write command. When a sequence completes, it raises a single-cycle start pulse for the matching embedded operation and latches the operands that operation needs: the program address and byte, or the sector number to erase. Single-write commands are handled outside that handshake. These are the return to read mode, erase suspend and erase resume.

The decoder also holds the array/identification mode. While identification mode is active, the read-data byte it presents depends on the address on the bus: a manufacturer code, a device code, or the protection state of the addressed sector. The program/erase engine reports through an `opBusy` input that an operation is running. While that input is high, the decoder accepts only the reset and suspend codes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `autoMode` is 0, all five start/request pulses are 0 and `progAddr`, `progData` and `eraseSector` are 0.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then any write (PA, PD) pulses `progStart` on the cycle after the final write. In that same cycle `progAddr` shows PA and `progData` shows PD.
- R3: Unlock and command addresses are matched on the low 11 address bits only. 3D55h counts as 555h, and 7AAAh counts as 2AAh. An address whose low 11 bits differ (for example 455h) is not accepted as an unlock write.
- R4: A write that does not match the expected address and data for the current step returns the sequencer to idle and starts nothing. A program data write that follows such a mismatch produces no `progStart`.
- R5: The sequence AAh@555h, 55h@2AAh, 90h@555h sets `autoMode` to 1. In that mode `idData` depends on the address. Address low byte 00h gives MFR_ID, in both 000h and 100h. Low byte 01h gives DEV_ID. Low byte 02h gives 00h or 01h, equal to bit `protMask[addr[18:16]]`. Any other low byte gives 00h. When `autoMode` is 0, `idData` is 00h.
- R6: A single write of F0h at any address clears `autoMode` and returns the sequencer to idle. So does the sequence AAh@555h, 55h@2AAh, F0h@555h.
- R7: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h pulses `chipEraseStart` on the cycle after the last write.
- R8: The same five-write prefix followed by 30h at address SA pulses `sectorEraseStart`, with `eraseSector` equal to SA[18:16].
- R9: While `opBusy` is 1, every write other than F0h and B0h is ignored. Such writes start nothing and leave no partial unlock progress behind.
- R10: A write of B0h while `opBusy` is 1 and the last operation started was a sector erase pulses `suspendReq`. B0h written with `opBusy` at 0, or after a program start, produces no pulse.
- R11: A single write of 30h while an erase is suspended and `opBusy` is 0 pulses `resumeReq` and ends the suspension. A single write of 30h when nothing is suspended produces no pulse.
- R12: Each start/request pulse lasts exactly one cycle, and at most one of the five is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | One-cycle bus write strobe |
| addr | input | 19 | Bus address (write and identification read) |
| wdata | input | 8 | Bus write data |
| opBusy | input | 1 | Embedded operation running |
| protMask | input | 8 | Per-sector protection flags, bit n for sector n |
| autoMode | output | 1 | Identification mode active |
| idData | output | 8 | Identification read byte for the current address |
| progStart | output | 1 | Byte program start pulse |
| chipEraseStart | output | 1 | Chip erase start pulse |
| sectorEraseStart | output | 1 | Sector erase start pulse |
| suspendReq | output | 1 | Erase suspend request pulse |
| resumeReq | output | 1 | Erase resume request pulse |
| progAddr | output | 19 | Latched program address |
| progData | output | 8 | Latched program byte |
| eraseSector | output | 3 | Latched sector number to erase |

## Verification
The hardest situation to reach from the ports is an erase that is suspended and then resumed. It needs a full six-write sector erase, then `opBusy` raised to stand in for the running engine, then B0h while busy, then `opBusy` dropped, and only then the single 30h. The bench walks exactly that chain in one task. It then repeats 30h to confirm that the suspension has cleared. It also issues partial unlock writes while busy and finishes the sequence after busy falls, which shows that the ignored writes left no hidden progress in the sequencer.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ESET,
    ST_EUNL1,
    ST_EUNL2
  } seqState_t;

  typedef struct packed {
    logic latchProg;
    logic latchSect;
    logic setAuto;
    logic setRead;
  } ctlStrobes_t;

  localparam logic [7:0] CODE_KEY1    = 8'hAA;
  localparam logic [7:0] CODE_KEY2    = 8'h55;
  localparam logic [7:0] CODE_RESET   = 8'hF0;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECT    = 8'h30;
  localparam logic [7:0] CODE_SUSPEND = 8'hB0;
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int UNLOCK_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [UNLOCK_W-1:0] addrLo,
  input  logic [7:0]          wdata,
  input  logic                opBusy,
  output ctlStrobes_t         ctl,
  output logic                progStart,
  output logic                chipEraseStart,
  output logic                sectorEraseStart,
  output logic                suspendReq,
  output logic                resumeReq
);
  localparam logic [UNLOCK_W-1:0] ADR_KEY1 = UNLOCK_W'(32'h555);
  localparam logic [UNLOCK_W-1:0] ADR_KEY2 = UNLOCK_W'(32'h2AA);

  seqState_t state, nState;
  logic sectErasing, nSectErasing;
  logic suspended, nSuspended;
  logic nProg, nChip, nSect, nSusp, nRes;
  logic atKey1, atKey2;

  assign atKey1 = (addrLo == ADR_KEY1);
  assign atKey2 = (addrLo == ADR_KEY2);

  always_comb begin
    nState       = state;
    nSectErasing = sectErasing;
    nSuspended   = suspended;
    ctl          = '0;
    nProg = 1'b0; nChip = 1'b0; nSect = 1'b0; nSusp = 1'b0; nRes = 1'b0;
    if (wrEn) begin
      if (opBusy) begin
        if (wdata == CODE_RESET) begin
          nState      = ST_IDLE;
          ctl.setRead = 1'b1;
        end else if (wdata == CODE_SUSPEND && sectErasing && !suspended) begin
          nSusp      = 1'b1;
          nSuspended = 1'b1;
        end
      end else if (state == ST_PROG) begin
        nProg         = 1'b1;
        ctl.latchProg = 1'b1;
        nSectErasing  = 1'b0;
        nState        = ST_IDLE;
      end else if (wdata == CODE_RESET) begin
        nState      = ST_IDLE;
        ctl.setRead = 1'b1;
      end else begin
        nState = ST_IDLE;
        unique case (state)
          ST_IDLE: begin
            if (wdata == CODE_KEY1 && atKey1) nState = ST_UNL1;
            else if (wdata == CODE_SECT && suspended) begin
              nRes       = 1'b1;
              nSuspended = 1'b0;
            end
          end
          ST_UNL1:  if (wdata == CODE_KEY2 && atKey2) nState = ST_UNL2;
          ST_UNL2: begin
            if (atKey1) begin
              if (wdata == CODE_IDENT) ctl.setAuto = 1'b1;
              else if (wdata == CODE_PROG) nState = ST_PROG;
              else if (wdata == CODE_ERASE) nState = ST_ESET;
            end
          end
          ST_ESET:  if (wdata == CODE_KEY1 && atKey1) nState = ST_EUNL1;
          ST_EUNL1: if (wdata == CODE_KEY2 && atKey2) nState = ST_EUNL2;
          ST_EUNL2: begin
            if (wdata == CODE_CHIP && atKey1) begin
              nChip        = 1'b1;
              nSectErasing = 1'b0;
            end else if (wdata == CODE_SECT) begin
              nSect         = 1'b1;
              ctl.latchSect = 1'b1;
              nSectErasing  = 1'b1;
            end
          end
          default: nState = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state            <= ST_IDLE;
      sectErasing      <= 1'b0;
      suspended        <= 1'b0;
      progStart        <= 1'b0;
      chipEraseStart   <= 1'b0;
      sectorEraseStart <= 1'b0;
      suspendReq       <= 1'b0;
      resumeReq        <= 1'b0;
    end else begin
      state            <= nState;
      sectErasing      <= nSectErasing;
      suspended        <= nSuspended;
      progStart        <= nProg;
      chipEraseStart   <= nChip;
      sectorEraseStart <= nSect;
      suspendReq       <= nSusp;
      resumeReq        <= nRes;
    end
  end
endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int         ADDR_W = 19,
  parameter int         SECT_W = 3,
  parameter logic [7:0] MFR_ID = 8'hA7,
  parameter logic [7:0] DEV_ID = 8'h3E
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [(1<<SECT_W)-1:0] protMask,
  output logic                autoMode,
  output logic [7:0]          idData,
  output logic [ADDR_W-1:0]   progAddr,
  output logic [7:0]          progData,
  output logic [SECT_W-1:0]   eraseSector
);
  localparam int SECT_LO = ADDR_W - SECT_W;

  logic [SECT_W-1:0] curSector;
  assign curSector = addr[ADDR_W-1:SECT_LO];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoMode    <= 1'b0;
      progAddr    <= '0;
      progData    <= '0;
      eraseSector <= '0;
    end else begin
      if (ctl.setRead) autoMode <= 1'b0;
      else if (ctl.setAuto) autoMode <= 1'b1;
      if (ctl.latchProg) begin
        progAddr <= addr;
        progData <= wdata;
      end
      if (ctl.latchSect) eraseSector <= curSector;
    end
  end

  always_comb begin
    idData = 8'h00;
    if (autoMode) begin
      case (addr[7:0])
        8'h00:   idData = MFR_ID;
        8'h01:   idData = DEV_ID;
        8'h02:   idData = {7'b0, protMask[curSector]};
        default: idData = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W   = 19,
  parameter int         SECT_W   = 3,
  parameter int         UNLOCK_W = 11,
  parameter logic [7:0] MFR_ID   = 8'hA7,
  parameter logic [7:0] DEV_ID   = 8'h3E
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  input  logic                       opBusy,
  input  logic [(1<<SECT_W)-1:0]     protMask,
  output logic                       autoMode,
  output logic [7:0]                 idData,
  output logic                       progStart,
  output logic                       chipEraseStart,
  output logic                       sectorEraseStart,
  output logic                       suspendReq,
  output logic                       resumeReq,
  output logic [ADDR_W-1:0]          progAddr,
  output logic [7:0]                 progData,
  output logic [SECT_W-1:0]          eraseSector
);
  ctlStrobes_t ctl;

  fcd_ctrl #(.UNLOCK_W(UNLOCK_W)) uCtrl (
    .clk              (clk),
    .rstN             (rstN),
    .wrEn             (wrEn),
    .addrLo           (addr[UNLOCK_W-1:0]),
    .wdata            (wdata),
    .opBusy           (opBusy),
    .ctl              (ctl),
    .progStart        (progStart),
    .chipEraseStart   (chipEraseStart),
    .sectorEraseStart (sectorEraseStart),
    .suspendReq       (suspendReq),
    .resumeReq        (resumeReq)
  );

  fcd_datapath #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .addr        (addr),
    .wdata       (wdata),
    .protMask    (protMask),
    .autoMode    (autoMode),
    .idData      (idData),
    .progAddr    (progAddr),
    .progData    (progData),
    .eraseSector (eraseSector)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              opBusy,
  input logic              progStart,
  input logic              chipEraseStart,
  input logic              sectorEraseStart,
  input logic              suspendReq,
  input logic              resumeReq,
  input logic [ADDR_W-1:0] progAddr,
  input logic [7:0]        progData,
  input logic [SECT_W-1:0] eraseSector
);
  a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, chipEraseStart, sectorEraseStart, suspendReq, resumeReq}));

  a_r12_prog_single: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  a_r2_prog_operands: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (progAddr == $past(addr) && progData == $past(wdata)));

  a_r8_sector_latch: assert property (@(posedge clk) disable iff (!rstN)
    sectorEraseStart |-> eraseSector == $past(addr[ADDR_W-1:ADDR_W-SECT_W]));

  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (progStart || chipEraseStart || sectorEraseStart) |-> !$past(opBusy));

  a_r10_suspend_busy: assert property (@(posedge clk) disable iff (!rstN)
    suspendReq |-> $past(opBusy));

  a_r11_resume_idle: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> !$past(opBusy));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) uChk (
  .clk              (clk),
  .rstN             (rstN),
  .addr             (addr),
  .wdata            (wdata),
  .opBusy           (opBusy),
  .progStart        (progStart),
  .chipEraseStart   (chipEraseStart),
  .sectorEraseStart (sectorEraseStart),
  .suspendReq       (suspendReq),
  .resumeReq        (resumeReq),
  .progAddr         (progAddr),
  .progData         (progData),
  .eraseSector      (eraseSector)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MFR = 8'hA7;
  localparam logic [7:0] DEV = 8'h3E;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        opBusy = 1'b0;
  logic [7:0]  protMask = 8'b0010_0100;
  logic        autoMode;
  logic [7:0]  idData;
  logic        progStart, chipEraseStart, sectorEraseStart, suspendReq, resumeReq;
  logic [18:0] progAddr;
  logic [7:0]  progData;
  logic [2:0]  eraseSector;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .opBusy(opBusy), .protMask(protMask), .autoMode(autoMode), .idData(idData),
    .progStart(progStart), .chipEraseStart(chipEraseStart),
    .sectorEraseStart(sectorEraseStart), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .progAddr(progAddr), .progData(progData),
    .eraseSector(eraseSector)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] pulses();
    return {progStart, chipEraseStart, sectorEraseStart, suspendReq, resumeReq};
  endfunction

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    addr = a; wdata = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h555, 8'hAA);
    wr(19'h2AA, 8'h55);
  endtask

  task automatic t_reset();
    check("R1 autoMode", autoMode, 0);
    check("R1 pulses", pulses(), 0);
    check("R1 progAddr", progAddr, 0);
    check("R1 progData", progData, 0);
    check("R1 eraseSector", eraseSector, 0);
  endtask

  task automatic t_program();
    unlock();
    wr(19'h555, 8'hA0);
    check("R2 no pulse before data", pulses(), 0);
    wr(19'h41234, 8'h5A);
    check("R2 progStart", pulses(), 5'b10000);
    check("R2 progAddr", progAddr, 19'h41234);
    check("R2 progData", progData, 8'h5A);
    @(negedge clk);
    check("R12 progStart one cycle", pulses(), 0);
  endtask

  task automatic t_alias();
    wr(19'h3D55, 8'hAA);
    wr(19'h7AAA, 8'h55);
    wr(19'h7D55, 8'hA0);
    wr(19'h00010, 8'h3C);
    check("R3 aliased unlock programs", progStart, 1);
    check("R3 aliased data", progData, 8'h3C);
    wr(19'h455, 8'hAA);
    wr(19'h2AA, 8'h55);
    wr(19'h555, 8'hA0);
    wr(19'h00100, 8'h77);
    check("R3 low bits differ no program", pulses(), 0);
  endtask

  task automatic t_mismatch();
    wr(19'h555, 8'hAA);
    wr(19'h2AA, 8'h54);
    wr(19'h555, 8'hA0);
    wr(19'h00200, 8'h11);
    check("R4 bad second write", pulses(), 0);
    unlock();
    wr(19'h555, 8'h77);
    wr(19'h00300, 8'h22);
    check("R4 bad command byte", pulses(), 0);
    check("R4 operands unchanged", progData, 8'h3C);
  endtask

  task automatic t_ident();
    unlock();
    wr(19'h555, 8'h90);
    check("R5 autoMode set", autoMode, 1);
    addr = 19'h00000; #1 check("R5 mfr 000", idData, MFR);
    addr = 19'h00100; #1 check("R5 mfr 100", idData, MFR);
    addr = 19'h00001; #1 check("R5 dev 001", idData, DEV);
    addr = 19'h00101; #1 check("R5 dev 101", idData, DEV);
    addr = 19'h20002; #1 check("R5 sector2 protected", idData, 8'h01);
    addr = 19'h30002; #1 check("R5 sector3 open", idData, 8'h00);
    addr = 19'h50002; #1 check("R5 sector5 protected", idData, 8'h01);
    addr = 19'h00005; #1 check("R5 other offset", idData, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_exit();
    wr(19'h12345, 8'hF0);
    check("R6 single reset write", autoMode, 0);
    addr = 19'h00000; #1 check("R5 idData zero in read mode", idData, 8'h00);
    @(negedge clk);
    unlock();
    wr(19'h555, 8'h90);
    check("R6 re-enter", autoMode, 1);
    unlock();
    wr(19'h555, 8'hF0);
    check("R6 sequenced reset", autoMode, 0);
  endtask

  task automatic t_chip();
    unlock();
    wr(19'h555, 8'h80);
    unlock();
    wr(19'h555, 8'h10);
    check("R7 chipEraseStart", pulses(), 5'b01000);
    @(negedge clk);
    check("R12 chip pulse one cycle", pulses(), 0);
  endtask

  task automatic t_busy();
    opBusy = 1'b1;
    unlock();
    wr(19'h555, 8'hA0);
    wr(19'h00100, 8'h12);
    check("R9 program ignored while busy", pulses(), 0);
    wr(19'h00000, 8'h30);
    check("R9 resume ignored while busy", pulses(), 0);
    wr(19'h00000, 8'hB0);
    check("R10 no suspend after chip erase", pulses(), 0);
    opBusy = 1'b0;
    wr(19'h555, 8'hA0);
    wr(19'h00200, 8'h34);
    check("R9 no leftover unlock progress", pulses(), 0);
    check("R9 operands kept", progData, 8'h3C);
  endtask

  task automatic t_sector_suspend();
    unlock();
    wr(19'h555, 8'h80);
    unlock();
    wr(19'h50123, 8'h30);
    check("R8 sectorEraseStart", pulses(), 5'b00100);
    check("R8 eraseSector", eraseSector, 3'd5);
    wr(19'h00000, 8'hB0);
    check("R10 B0 not busy ignored", pulses(), 0);
    opBusy = 1'b1;
    wr(19'h00000, 8'hB0);
    check("R10 suspendReq", pulses(), 5'b00010);
    @(negedge clk);
    check("R12 suspend one cycle", pulses(), 0);
    opBusy = 1'b0;
    wr(19'h00777, 8'h30);
    check("R11 resumeReq", pulses(), 5'b00001);
    wr(19'h00777, 8'h30);
    check("R11 no resume when not suspended", pulses(), 0);
  endtask

  task automatic t_prog_then_b0();
    unlock();
    wr(19'h555, 8'hA0);
    wr(19'h00040, 8'h99);
    check("R2 second program", progData, 8'h99);
    opBusy = 1'b1;
    wr(19'h00000, 8'hB0);
    check("R10 no suspend during program", pulses(), 0);
    opBusy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_alias();
    t_mismatch();
    t_ident();
    t_exit();
    t_chip();
    t_busy();
    t_sector_suspend();
    t_prog_then_b0();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule